// File: doc/BRIEF.md
# Predicated Scatter-Store Address Sequencer

This block carries out one vector scatter store of 64-bit elements. A start pulse arrives with a 32-bit instruction word, a stack pointer value and a general register value. In the same cycle the caller supplies an index vector, a source data vector and one predicate bit per element.

The block decodes the word and chooses the base register. It checks stack alignment when the stack pointer is the base. It then steps through the elements from lowest to highest. Each element whose predicate bit is set produces one 8-byte write request on a valid/ready port. The request address is the base plus the element's index. The index is first truncated, then zero- or sign-extended, and is multiplied by 8 when the scaled form is selected.

The block decodes the register selectors for the zm, zt and pg fields and drives them as outputs. The surrounding register files use them to supply the vectors and the mask. An illegal encoding, or a misaligned stack pointer, ends the operation with a fault pulse and no writes.

The state machine has five states:
- IDLE: waits for start.
- LOAD: the inputs are latched and the fault check is made.
- WALK: one element is handled per step.
- FAULT: one cycle with fault and done high.
- DONE: one cycle with done high.

The transitions are:
- IDLE to LOAD on start.
- LOAD to FAULT when the word is illegal or the stack is misaligned.
- LOAD to DONE when every predicate bit is clear.
- LOAD to WALK otherwise.
- WALK to DONE when the last element advances.
- FAULT and DONE each return to IDLE.

Top module: `scat_seq`

## Requirements
- R1: A word is legal only when bits [31:22] equal 1110010110 and bits [15:13] are 100, 110 or 101. Any other word gives a one-cycle fault pulse together with done, and issues no write request.
- R2: The outputs zm_sel, pg_sel, base_sel and zt_sel follow instr bits [20:16], [12:10], [9:5] and [4:0] combinationally.
- R3: When instr[9:5] is 31 the base is sp_val. Otherwise the base is gpr_rdata. Both are sampled in the start cycle.
- R4: When the base is sp_val and its low 4 bits are not all zero, the operation faults (fault and done high for one cycle) and issues no write.
- R5: Form bits [15:13] = 1,x,0 use only index bits [31:0]. The index is zero-extended when bit 14 is 0 and sign-extended when bit 14 is 1.
- R6: Form 101 uses the full 64-bit index as an unsigned value.
- R7: Bit 21 = 1 shifts the extended index left by 3. Bit 21 = 0 uses it unshifted.
- R8: Address arithmetic wraps modulo 2^64.
- R9: Element e takes index bits [64e+63:64e] and data bits [64e+63:64e]. Requests are issued in ascending e. An element with pred[e]=0 produces no request.
- R10: While wr_valid is high and wr_ready is low, the request holds unchanged. One handshake advances exactly one element.
- R11: After reset, wr_valid, done and fault are low. After the last element, done is high for exactly one cycle.
- R12: When every predicate bit is clear, done is raised without any request.
- R13: start is ignored while an operation is in progress. Inputs that change after the start cycle have no effect on that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted in IDLE only) |
| instr | input | 32 | Instruction word |
| sp_val | input | 64 | Stack pointer value |
| gpr_rdata | input | 64 | Value of the general register named by base_sel |
| idx_vec | input | VL_BITS | Index vector, element e at bits [64e+63:64e] |
| src_vec | input | VL_BITS | Source data vector |
| pred | input | VL_BITS/64 | Predicate bit per element |
| base_sel | output | 5 | Base register number |
| zm_sel | output | 5 | Index vector register number |
| zt_sel | output | 5 | Source vector register number |
| pg_sel | output | 3 | Predicate register number |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 64 | Write byte address |
| wr_data | output | 64 | Write data (8 bytes) |
| done | output | 1 | One-cycle end-of-operation pulse |
| fault | output | 1 | One-cycle fault pulse, raised with done |

## Verification
Two events can fall into the same cycle:
- a busy operation stalled by wr_ready;
- a fresh start pulse carrying a different word and different vectors.

The bench provokes this by raising start mid-walk. It also scrambles every input right after the accepted start. It judges the result by checking that each recorded request still matches the model built from the original inputs, and that the request count is unchanged.

Randomly withheld wr_ready is also made to coincide with inactive elements, which skip without a handshake. The bench judges that case by requiring exactly one recorded transfer per active element, in ascending order.

// File: rtl/scat_pkg.sv
package scat_pkg;

    localparam logic [9:0] OPC_FIXED = 10'b1110010110;
    localparam logic [4:0] SP_REG_NUM = 5'd31;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_WALK,
        S_FAULT,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        OFF_U32,
        OFF_S32,
        OFF_U64
    } off_kind_t;

    typedef struct packed {
        logic      legal;
        logic      scaled;
        off_kind_t kind;
        logic [4:0] zm;
        logic [4:0] rn;
        logic [4:0] zt;
        logic [2:0] pg;
    } dec_t;

endpackage

// File: rtl/scat_decode.sv
module scat_decode
    import scat_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    logic form_ok;

    always_comb begin
        dec        = '0;
        form_ok    = 1'b0;
        dec.zm     = instr[20:16];
        dec.rn     = instr[9:5];
        dec.zt     = instr[4:0];
        dec.pg     = instr[12:10];
        dec.scaled = instr[21];
        dec.kind   = OFF_U64;
        unique casez (instr[15:13])
            3'b101: begin
                dec.kind = OFF_U64;
                form_ok  = 1'b1;
            end
            3'b1?0: begin
                dec.kind = instr[14] ? OFF_S32 : OFF_U32;
                form_ok  = 1'b1;
            end
            default: begin
                dec.kind = OFF_U64;
                form_ok  = 1'b0;
            end
        endcase
        dec.legal = form_ok && (instr[31:22] == OPC_FIXED);
    end

endmodule

// File: rtl/scat_elem_pick.sv
module scat_elem_pick #(
    parameter int NE = 8,
    parameter int EW = 64,
    localparam int CW = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic [NE*EW-1:0] vec,
    input  logic [CW-1:0]    sel,
    output logic [EW-1:0]    elem
);

    logic [EW-1:0] lanes [NE];

    for (genvar g = 0; g < NE; g++) begin : g_lane
        assign lanes[g] = vec[g*EW +: EW];
    end

    assign elem = lanes[sel];

endmodule

// File: rtl/scat_addr_gen.sv
module scat_addr_gen
    import scat_pkg::*;
#(
    parameter int AW    = 64,
    parameter int SHIFT = 3
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  off_kind_t     kind,
    input  logic          scaled,
    output logic [AW-1:0] addr
);

    localparam int HALF = AW / 2;

    logic [AW-1:0] ext;
    logic [AW-1:0] offs;

    always_comb begin
        unique case (kind)
            OFF_U32: ext = {{HALF{1'b0}}, index[HALF-1:0]};
            OFF_S32: ext = {{HALF{index[HALF-1]}}, index[HALF-1:0]};
            default: ext = index;
        endcase
        offs = scaled ? (ext << SHIFT) : ext;
        addr = base + offs;
    end

endmodule

// File: rtl/scat_seq.sv
module scat_seq
    import scat_pkg::*;
#(
    parameter int VL_BITS  = 512,
    parameter int SP_ALIGN = 16,
    localparam int EW = 64,
    localparam int NE = VL_BITS / EW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [31:0]        instr,
    input  logic [63:0]        sp_val,
    input  logic [63:0]        gpr_rdata,
    input  logic [VL_BITS-1:0] idx_vec,
    input  logic [VL_BITS-1:0] src_vec,
    input  logic [NE-1:0]      pred,
    output logic [4:0]         base_sel,
    output logic [4:0]         zm_sel,
    output logic [4:0]         zt_sel,
    output logic [2:0]         pg_sel,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [63:0]        wr_addr,
    output logic [63:0]        wr_data,
    output logic               done,
    output logic               fault
);

    localparam int CW = (NE > 1) ? $clog2(NE) : 1;
    localparam int AB = $clog2(SP_ALIGN);

    dec_t          dec_now;
    seq_state_t    state_q, state_d;

    logic          legal_q, scaled_q, rn_sp_q;
    off_kind_t     kind_q;
    logic [63:0]   base_q;
    logic [VL_BITS-1:0] idx_q, src_q;
    logic [NE-1:0] pred_q;
    logic [CW-1:0] elem_q;

    logic [63:0]   cur_idx, cur_src, cur_addr;
    logic          take, step, last, misaligned, bad_op, cur_active;

    scat_decode u_dec (
        .instr (instr),
        .dec   (dec_now)
    );

    assign base_sel = dec_now.rn;
    assign zm_sel   = dec_now.zm;
    assign zt_sel   = dec_now.zt;
    assign pg_sel   = dec_now.pg;

    assign take       = (state_q == S_IDLE) && start;
    assign cur_active = pred_q[elem_q];
    assign step       = (state_q == S_WALK) && (!cur_active || wr_ready);
    assign last       = (elem_q == CW'(NE - 1));
    assign misaligned = rn_sp_q && (base_q[AB-1:0] != '0);
    assign bad_op     = !legal_q || misaligned;

    // operand capture and element counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            legal_q  <= 1'b0;
            scaled_q <= 1'b0;
            rn_sp_q  <= 1'b0;
            kind_q   <= OFF_U64;
            base_q   <= '0;
            idx_q    <= '0;
            src_q    <= '0;
            pred_q   <= '0;
            elem_q   <= '0;
        end else begin
            if (take) begin
                legal_q  <= dec_now.legal;
                scaled_q <= dec_now.scaled;
                kind_q   <= dec_now.kind;
                rn_sp_q  <= (dec_now.rn == SP_REG_NUM);
                base_q   <= (dec_now.rn == SP_REG_NUM) ? sp_val : gpr_rdata;
                idx_q    <= idx_vec;
                src_q    <= src_vec;
                pred_q   <= pred;
            end
            if (state_q == S_LOAD) begin
                elem_q <= '0;
            end else if (step && !last) begin
                elem_q <= elem_q + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_LOAD;
            S_LOAD: begin
                if (bad_op)              state_d = S_FAULT;
                else if (pred_q == '0)   state_d = S_DONE;
                else                     state_d = S_WALK;
            end
            S_WALK:  if (step && last) state_d = S_DONE;
            S_FAULT: state_d = S_IDLE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    scat_elem_pick #(.NE(NE), .EW(EW)) u_pick_idx (
        .vec  (idx_q),
        .sel  (elem_q),
        .elem (cur_idx)
    );

    scat_elem_pick #(.NE(NE), .EW(EW)) u_pick_src (
        .vec  (src_q),
        .sel  (elem_q),
        .elem (cur_src)
    );

    scat_addr_gen #(.AW(64), .SHIFT(3)) u_agen (
        .base   (base_q),
        .index  (cur_idx),
        .kind   (kind_q),
        .scaled (scaled_q),
        .addr   (cur_addr)
    );

    assign wr_addr = cur_addr;
    assign wr_data = cur_src;

    // outputs by state
    always_comb begin
        wr_valid = 1'b0;
        done     = 1'b0;
        fault    = 1'b0;
        unique case (state_q)
            S_WALK:  wr_valid = cur_active;
            S_FAULT: begin
                fault = 1'b1;
                done  = 1'b1;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/scat_seq_chk.sv
module scat_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [63:0] wr_addr,
    input logic [63:0] wr_data,
    input logic        done,
    input logic        fault
);

    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_fault_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    a_r4_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !wr_valid);

    a_r9_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_valid);

endmodule

bind scat_seq scat_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .done     (done),
    .fault    (fault)
);

// File: tb/test_scat_seq.sv
module test_scat_seq;

    localparam int VL = 512;
    localparam int NE = VL / 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   instr = '0;
    logic [63:0]   sp_val = '0;
    logic [63:0]   gpr_rdata = '0;
    logic [VL-1:0] idx_vec = '0;
    logic [VL-1:0] src_vec = '0;
    logic [NE-1:0] pred = '0;
    logic          wr_ready = 1'b0;
    logic [4:0]    base_sel, zm_sel, zt_sel;
    logic [2:0]    pg_sel;
    logic          wr_valid, done, fault;
    logic [63:0]   wr_addr, wr_data;

    int errs = 0;
    int checks = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    scat_seq #(.VL_BITS(VL), .SP_ALIGN(16)) i_scat_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .sp_val(sp_val), .gpr_rdata(gpr_rdata), .idx_vec(idx_vec),
        .src_vec(src_vec), .pred(pred), .base_sel(base_sel),
        .zm_sel(zm_sel), .zt_sel(zt_sel), .pg_sel(pg_sel),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .fault(fault)
    );

    // scaled, form[2:0], rn[4:0], gpr, sp, pred, index base
    localparam int NT = 9;
    localparam logic [208:0] TBL [NT] = '{
        {1'b1, 3'b101, 5'd3,  64'h0000_0000_0000_1000, 64'h0, 8'hFF, 64'h0000_0000_0000_0004},
        {1'b0, 3'b101, 5'd7,  64'h2000_0000_0000_0000, 64'h0, 8'hA5, 64'hFFFF_FFFF_FFFF_FFF0},
        {1'b1, 3'b100, 5'd1,  64'h0000_0000_0000_8000, 64'h0, 8'hFF, 64'h1234_5678_FFFF_FFF8},
        {1'b1, 3'b110, 5'd1,  64'h0000_0000_0000_8000, 64'h0, 8'h3C, 64'h1234_5678_FFFF_FFF8},
        {1'b0, 3'b110, 5'd31, 64'hDEAD_BEEF_0000_0000, 64'h7000_0000_0000_0010, 8'h81, 64'h0000_0000_7FFF_FFFE},
        {1'b0, 3'b100, 5'd31, 64'h0, 64'h7000_0000_0000_0018, 8'hFF, 64'h10},
        {1'b1, 3'b111, 5'd4,  64'h100, 64'h0, 8'hFF, 64'h10},
        {1'b0, 3'b101, 5'd0,  64'h400, 64'h0, 8'h00, 64'h10},
        {1'b0, 3'b010, 5'd5,  64'h400, 64'h0, 8'h0F, 64'h0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_addr(input logic [31:0] ins, input logic [63:0] base,
                                               input logic [63:0] ix);
        logic [63:0] off;
        if (ins[15:13] == 3'b101) off = ix;
        else if (ins[14])        off = {{32{ix[31]}}, ix[31:0]};
        else                     off = {32'h0, ix[31:0]};
        return base + (ins[21] ? (off << 3) : off);
    endfunction

    function automatic bit model_fault(input logic [31:0] ins, input logic [63:0] sp);
        bit ok;
        ok = (ins[31:22] == 10'b1110010110) &&
             (ins[15:13] == 3'b101 || ins[15:13] == 3'b100 || ins[15:13] == 3'b110);
        return !ok || (ins[9:5] == 5'd31 && sp[3:0] != 4'h0);
    endfunction

    function automatic logic [31:0] mk_instr(input bit sc, input logic [2:0] form,
                                             input logic [4:0] rn, input int n);
        return {10'b1110010110, sc, 5'(n + 4), form, 3'(n), rn, 5'(n + 9)};
    endfunction

    task automatic run_case(input logic [31:0] ins, input logic [63:0] gpr, input logic [63:0] sp,
                            input logic [NE-1:0] pm, input logic [63:0] ib, input int cnum,
                            input string atag, input bit hit_busy, input bit full_ready);
        logic [63:0] ea [NE];
        logic [63:0] ed [NE];
        logic [63:0] base;
        int en, got;
        bit ef, seen_done;
        string ftag, ctag;
        en = 0; got = 0; seen_done = 0;
        ef = model_fault(ins, sp);
        base = (ins[9:5] == 5'd31) ? sp : gpr;
        ftag = (ins[9:5] == 5'd31) ? "R4" : "R1";
        ctag = (pm == '0) ? "R12" : "R9";
        @(negedge clk);
        for (int e = 0; e < NE; e++) begin
            logic [63:0] ix, dv;
            ix = ib + 64'(e) * 64'h0000_0001_0000_0001;
            dv = 64'hDA7A_0000_0000_0000 | (64'(cnum) << 16) | 64'(e);
            idx_vec[e*64 +: 64] = ix;
            src_vec[e*64 +: 64] = dv;
            if (pm[e] && !ef) begin
                ea[en] = model_addr(ins, base, ix);
                ed[en] = dv;
                en++;
            end
        end
        instr = ins; gpr_rdata = gpr; sp_val = sp; pred = pm; start = 1'b1;
        #1;
        chk({zm_sel, pg_sel, base_sel, zt_sel} == {ins[20:16], ins[12:10], ins[9:5], ins[4:0]},
            "R2 selects", 64'({zm_sel, pg_sel, base_sel, zt_sel}),
            64'({ins[20:16], ins[12:10], ins[9:5], ins[4:0]}));
        for (int cyc = 0; cyc < 300; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            if (cyc == 0) begin
                instr = ~ins; gpr_rdata = ~gpr; sp_val = ~sp; pred = ~pm;
                idx_vec = ~idx_vec; src_vec = ~src_vec;
            end
            if (hit_busy && cyc == 2) begin
                start = 1'b1;
                instr = mk_instr(1'b0, 3'b101, 5'd2, 1);
            end
            wr_ready = full_ready ? 1'b1 : lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            if (wr_valid && wr_ready) begin
                if (got < en) begin
                    chk(wr_addr == ea[got], atag, wr_addr, ea[got]);
                    chk(wr_data == ed[got], "R9 data order", wr_data, ed[got]);
                end else begin
                    chk(1'b0, "R9 extra write", wr_addr, 64'h0);
                end
                got++;
            end
            if (done) begin
                seen_done = 1'b1;
                chk(fault == ef, ftag, 64'(fault), 64'(ef));
                break;
            end
        end
        start = 1'b0;
        chk(seen_done, "R11 done seen", 64'(seen_done), 64'h1);
        chk(got == en, ctag, 64'(got), 64'(en));
        @(negedge clk);
        chk(!done && !wr_valid, "R11 single done", 64'({done, wr_valid}), 64'h0);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errs++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!wr_valid && !done && !fault, "R11 reset state", 64'({wr_valid, done, fault}), 64'h0);

        for (int i = 0; i < NT; i++) begin
            logic [208:0] r;
            logic [31:0] ins;
            string tag;
            r = TBL[i];
            ins = mk_instr(r[208], r[207:205], r[204:200], i);
            tag = (r[207:205] == 3'b101) ? (r[208] ? "R6/R7 addr" : "R6 addr")
                                         : (r[208] ? "R5/R7 addr" : "R5 addr");
            run_case(ins, r[199:136], r[135:72], r[71:64], r[63:0], i, tag, 1'b0, 1'b0);
        end

        // R3: general register chosen while sp differs
        run_case(mk_instr(1'b0, 3'b101, 5'd9, 10), 64'h0000_0000_0000_ABC0,
                 64'h0000_0000_0000_5550, 8'h03, 64'h8, 10, "R3 gpr base", 1'b0, 1'b0);
        // R3: stack pointer chosen for register 31
        run_case(mk_instr(1'b0, 3'b101, 5'd31, 11), 64'h0000_0000_0000_0900,
                 64'h0000_0000_0000_0100, 8'h03, 64'h8, 11, "R3 sp base", 1'b0, 1'b0);
        // R8: wrap past 2^64
        run_case(mk_instr(1'b1, 3'b101, 5'd2, 12), 64'hFFFF_FFFF_FFFF_FFF8,
                 64'h0, 8'h01, 64'h2, 12, "R8 wrap", 1'b0, 1'b0);
        // R1: opcode bit flipped
        run_case(mk_instr(1'b0, 3'b101, 5'd2, 13) ^ 32'h8000_0000, 64'h1000,
                 64'h0, 8'hFF, 64'h8, 13, "R1 illegal", 1'b0, 1'b0);
        // R13: start pulsed mid-walk, inputs scrambled after start
        run_case(mk_instr(1'b1, 3'b110, 5'd6, 14), 64'h0000_0000_0010_0000,
                 64'h0, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFC, 14, "R13 busy start", 1'b1, 1'b0);
        // R10: back-to-back acceptance
        run_case(mk_instr(1'b0, 3'b100, 5'd8, 15), 64'h0000_0000_4000_0000,
                 64'h0, 8'hF7, 64'h40, 15, "R10 back-to-back", 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule